// File: doc/BRIEF.md
# Per-Core Local Compare Interrupt Unit

This block holds one small register bank per core for a timer-compare interrupt. The shared system counter comes in on a port. When it equals a core's compare value, that core's compare-pending flag latches. If the compare source is unmasked and routed to a pin, one line of that core's interrupt-pin vector goes high. The flag stays set until software writes the compare value again.

Software reaches the banks through a single-cycle register port. Each access names the requesting core and one of two windows. The local window goes to the requester's own bank. The redirect window goes to the bank whose index the requester last stored in its redirect pointer, which lets one core set up another core's timer.

The local mask has separate set and clear write offsets. Routing writes that name an impossible pin are discarded. The control and upper-compare registers exist only as fixed reads. Reads are combinational from the current state, so read data is valid in the same cycle as the request.

Top module: `local_cmp_irq`

## Requirements
- R1: On each rising edge where `sharedCount` equals a core's compare value and no compare write targets that core, the core's pending flag is set. The flag is visible on `cmpPend[k]` and as bit 1 of the PEND register (offset 1) from the following cycle. It stays set when the counter moves on.
- R2: A write to CMPLO (offset 8) stores the full 32-bit compare value and clears that core's pending flag. If a match occurs in the same cycle, the clear wins.
- R3: `pinOut[k*NUM_PINS+p]` is high exactly when core k's pending flag, its mask bit 1 and its map flag (bit 31 of MAP) are all set and its map pin field (bits 5:0) equals p. At most one pin per core is high.
- R4: A write to MASKSET (offset 4) ORs data bits 5:0 into the 6-bit mask, and a write to MASKCLR (offset 3) clears the mask bits where data bits 5:0 are one. Higher data bits are ignored, and the mask reads back at MASK (offset 2).
- R5: A write to MAP (offset 5) is dropped when data bits 5:0 exceed `MAX_PIN`. Otherwise only bit 31 and bits 5:0 are stored, and other bits read back as zero.
- R6: A write to OTHER (offset 6) is accepted only when the data is below `NUM_CORES`. With `reqOther=1`, reads and writes go to the bank whose index the requester's OTHER holds.
- R7: IDENT (offset 7) reads the index of the addressed bank. CTL (offset 0) and CMPHI (offset 9) read zero, and writes to CTL change nothing.
- R8: After reset every bank reads CTL=0, PEND=0, MASK=0x32, MAP=0x80000000, CMPLO=0xFFFFFFFF and OTHER=0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sharedCount | input | 32 | Shared system counter value |
| reqValid | input | 1 | Register access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOther | input | 1 | 1 = redirect window, 0 = own bank |
| reqCore | input | CW | Index of the requesting core |
| reqAddr | input | 4 | Register word offset |
| reqWdata | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational |
| cmpPend | output | NUM_CORES | Per-core compare-pending flag |
| pinOut | output | NUM_CORES*NUM_PINS | Per-core interrupt pin vector |

## Verification
The assertions check the per-core timing rules on every cycle:
- a match with no competing write latches the flag;
- the flag holds until a compare write, and that write leaves it clear;
- a pin is never high without the flag, and at most one pin per core is high;
- the redirect pointer never leaves the core range.

Some behaviour can only be shown by the bench's scenarios:
- register contents and read-back encodings;
- dropped routing and pointer writes;
- the set and clear mask arithmetic;
- redirection through the other window;
- reset values.

The bench sweeps every mask data byte and every pin-field value with both flag states, and it runs the match sequence on every core.

// File: rtl/lci_pkg.sv
package lci_pkg;
  localparam int REG_W        = 32;
  localparam int MASK_W       = 6;
  localparam int PIN_FIELD_W  = 6;
  localparam int CMP_BIT      = 1;
  localparam int MAP_FLAG_BIT = 31;
  localparam logic [MASK_W-1:0] MASK_RST = 6'h32;

  localparam logic [3:0] OFF_CTL     = 4'd0;
  localparam logic [3:0] OFF_PEND    = 4'd1;
  localparam logic [3:0] OFF_MASK    = 4'd2;
  localparam logic [3:0] OFF_MASKCLR = 4'd3;
  localparam logic [3:0] OFF_MASKSET = 4'd4;
  localparam logic [3:0] OFF_MAP     = 4'd5;
  localparam logic [3:0] OFF_OTHER   = 4'd6;
  localparam logic [3:0] OFF_IDENT   = 4'd7;
  localparam logic [3:0] OFF_CMPLO   = 4'd8;
  localparam logic [3:0] OFF_CMPHI   = 4'd9;

  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic mapWr;
    logic otherWr;
    logic cmpWr;
  } strobe_t;
endpackage

// File: rtl/lci_ctrl.sv
module lci_ctrl
  import lci_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int MAX_PIN   = 5,
  parameter int CW        = 2
) (
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic                    reqOther,
  input  logic [CW-1:0]           reqCore,
  input  logic [3:0]              reqAddr,
  input  logic [REG_W-1:0]        reqWdata,
  input  logic [NUM_CORES*CW-1:0] otherFlat,
  output logic [CW-1:0]           tgtCore,
  output logic                    tgtValid,
  output strobe_t                 stb
);
  logic [CW-1:0] ownPtr;
  logic          coreOk;
  logic          pinOk;
  logic          otherOk;
  logic          wrEn;

  always_comb begin
    ownPtr = '0;
    coreOk = 1'b0;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (reqCore == CW'(k)) begin
        ownPtr = otherFlat[k*CW +: CW];
        coreOk = 1'b1;
      end
    end
  end

  assign tgtCore  = reqOther ? ownPtr : reqCore;
  assign tgtValid = reqValid && coreOk;
  assign pinOk    = reqWdata[PIN_FIELD_W-1:0] <= PIN_FIELD_W'(MAX_PIN);
  assign otherOk  = reqWdata < REG_W'(NUM_CORES);
  assign wrEn     = tgtValid && reqWrite;

  always_comb begin
    stb         = '0;
    stb.maskSet = wrEn && (reqAddr == OFF_MASKSET);
    stb.maskClr = wrEn && (reqAddr == OFF_MASKCLR);
    stb.mapWr   = wrEn && (reqAddr == OFF_MAP) && pinOk;
    stb.otherWr = wrEn && (reqAddr == OFF_OTHER) && otherOk;
    stb.cmpWr   = wrEn && (reqAddr == OFF_CMPLO);
  end
endmodule

// File: rtl/lci_datapath.sv
module lci_datapath
  import lci_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_PINS  = 6,
  parameter int CW        = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [REG_W-1:0]           sharedCount,
  input  logic [CW-1:0]              tgtCore,
  input  logic                       tgtValid,
  input  strobe_t                    stb,
  input  logic [3:0]                 reqAddr,
  input  logic [REG_W-1:0]           reqWdata,
  output logic [REG_W-1:0]           rdData,
  output logic [NUM_CORES*CW-1:0]    otherFlat,
  output logic [NUM_CORES*REG_W-1:0] cmpFlat,
  output logic [NUM_CORES-1:0]       cmpPend,
  output logic [NUM_CORES*NUM_PINS-1:0] pinOut
);
  logic [NUM_CORES*MASK_W-1:0]      maskFlat;
  logic [NUM_CORES*PIN_FIELD_W-1:0] pinFlat;
  logic [NUM_CORES-1:0]             flagVec;

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_bank
    logic                   sel;
    logic                   pendQ;
    logic [MASK_W-1:0]      maskQ;
    logic                   flagQ;
    logic [PIN_FIELD_W-1:0] pinQ;
    logic [CW-1:0]          otherQ;
    logic [REG_W-1:0]       cmpQ;

    assign sel = (tgtCore == CW'(k));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ  <= 1'b0;
        maskQ  <= MASK_RST;
        flagQ  <= 1'b1;
        pinQ   <= '0;
        otherQ <= '0;
        cmpQ   <= '1;
      end else begin
        if (sel && stb.maskSet) maskQ <= maskQ | reqWdata[MASK_W-1:0];
        if (sel && stb.maskClr) maskQ <= maskQ & ~reqWdata[MASK_W-1:0];
        if (sel && stb.mapWr) begin
          flagQ <= reqWdata[MAP_FLAG_BIT];
          pinQ  <= reqWdata[PIN_FIELD_W-1:0];
        end
        if (sel && stb.otherWr) otherQ <= reqWdata[CW-1:0];
        if (sel && stb.cmpWr) begin
          cmpQ  <= reqWdata;
          pendQ <= 1'b0;
        end else if (sharedCount == cmpQ) begin
          pendQ <= 1'b1;
        end
      end
    end

    assign cmpPend[k]                            = pendQ;
    assign maskFlat[k*MASK_W +: MASK_W]          = maskQ;
    assign flagVec[k]                            = flagQ;
    assign pinFlat[k*PIN_FIELD_W +: PIN_FIELD_W] = pinQ;
    assign otherFlat[k*CW +: CW]                 = otherQ;
    assign cmpFlat[k*REG_W +: REG_W]             = cmpQ;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign pinOut[k*NUM_PINS+p] = pendQ && maskQ[CMP_BIT] && flagQ &&
                                    (pinQ == PIN_FIELD_W'(p));
    end
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (tgtValid && tgtCore == CW'(k)) begin
        case (reqAddr)
          OFF_PEND:  rdData[CMP_BIT] = cmpPend[k];
          OFF_MASK:  rdData[MASK_W-1:0] = maskFlat[k*MASK_W +: MASK_W];
          OFF_MAP: begin
            rdData[MAP_FLAG_BIT]      = flagVec[k];
            rdData[PIN_FIELD_W-1:0]   = pinFlat[k*PIN_FIELD_W +: PIN_FIELD_W];
          end
          OFF_OTHER: rdData[CW-1:0] = otherFlat[k*CW +: CW];
          OFF_IDENT: rdData[CW-1:0] = CW'(k);
          OFF_CMPLO: rdData = cmpFlat[k*REG_W +: REG_W];
          default:   rdData = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/local_cmp_irq.sv
module local_cmp_irq
  import lci_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int MAX_PIN   = 5,
  parameter int NUM_PINS  = MAX_PIN + 1,
  parameter int CW        = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [31:0]                   sharedCount,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic                          reqOther,
  input  logic [CW-1:0]                 reqCore,
  input  logic [3:0]                    reqAddr,
  input  logic [31:0]                   reqWdata,
  output logic [31:0]                   rdData,
  output logic [NUM_CORES-1:0]          cmpPend,
  output logic [NUM_CORES*NUM_PINS-1:0] pinOut
);
  logic [CW-1:0]              tgtCore;
  logic                       tgtValid;
  strobe_t                    stb;
  logic [NUM_CORES*CW-1:0]    otherFlat;
  logic [NUM_CORES*REG_W-1:0] cmpFlat;

  lci_ctrl #(.NUM_CORES(NUM_CORES), .MAX_PIN(MAX_PIN), .CW(CW)) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqOther(reqOther),
    .reqCore(reqCore), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .otherFlat(otherFlat), .tgtCore(tgtCore), .tgtValid(tgtValid), .stb(stb)
  );

  lci_datapath #(.NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .sharedCount(sharedCount), .tgtCore(tgtCore),
    .tgtValid(tgtValid), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdData(rdData), .otherFlat(otherFlat), .cmpFlat(cmpFlat),
    .cmpPend(cmpPend), .pinOut(pinOut)
  );
endmodule

// File: rtl/lci_checker.sv
module lci_checker
  import lci_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_PINS  = 6,
  parameter int CW        = 2
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [31:0]                   sharedCount,
  input logic [CW-1:0]                 tgtCore,
  input strobe_t                       stb,
  input logic [NUM_CORES*CW-1:0]       otherFlat,
  input logic [NUM_CORES*REG_W-1:0]    cmpFlat,
  input logic [NUM_CORES-1:0]          cmpPend,
  input logic [NUM_CORES*NUM_PINS-1:0] pinOut
);
  for (genvar k = 0; k < NUM_CORES; k++) begin : g_chk
    logic cmpWrK;
    assign cmpWrK = stb.cmpWr && (tgtCore == CW'(k));

    p_match_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
      (sharedCount == cmpFlat[k*REG_W +: REG_W]) && !cmpWrK |=> cmpPend[k]);

    p_pend_holds_r1: assert property (@(posedge clk) disable iff (!rstN)
      cmpPend[k] && !cmpWrK |=> cmpPend[k]);

    p_cmp_write_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
      cmpWrK |=> !cmpPend[k]);

    p_pin_needs_pend_r3: assert property (@(posedge clk) disable iff (!rstN)
      (|pinOut[k*NUM_PINS +: NUM_PINS]) |-> cmpPend[k]);

    p_one_pin_r3: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(pinOut[k*NUM_PINS +: NUM_PINS]));

    p_other_range_r6: assert property (@(posedge clk) disable iff (!rstN)
      int'(otherFlat[k*CW +: CW]) < NUM_CORES);
  end
endmodule

bind local_cmp_irq lci_checker #(.NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .sharedCount(sharedCount), .tgtCore(tgtCore),
  .stb(stb), .otherFlat(otherFlat), .cmpFlat(cmpFlat),
  .cmpPend(cmpPend), .pinOut(pinOut)
);

// File: tb/local_cmp_irq_bench.sv
module local_cmp_irq_bench;
  localparam int NC = 4;
  localparam int MAXP = 5;
  localparam int NP = MAXP + 1;
  localparam int CW = 2;

  logic clk = 0;
  logic rstN = 0;
  logic [31:0] sharedCount = 0;
  logic reqValid = 0, reqWrite = 0, reqOther = 0;
  logic [CW-1:0] reqCore = 0;
  logic [3:0] reqAddr = 0;
  logic [31:0] reqWdata = 0;
  logic [31:0] rdData;
  logic [NC-1:0] cmpPend;
  logic [NC*NP-1:0] pinOut;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  local_cmp_irq #(.NUM_CORES(NC), .MAX_PIN(MAXP)) u_local_cmp_irq (
    .clk(clk), .rstN(rstN), .sharedCount(sharedCount), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqOther(reqOther), .reqCore(reqCore),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdData(rdData),
    .cmpPend(cmpPend), .pinOut(pinOut)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int core, bit oth, logic [3:0] addr, logic [31:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqOther = oth; reqCore = CW'(core);
    reqAddr = addr; reqWdata = d;
    @(negedge clk);
    reqValid = 0; reqWrite = 0; reqOther = 0;
  endtask

  task automatic rd(int core, bit oth, logic [3:0] addr, output logic [31:0] q);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqOther = oth; reqCore = CW'(core);
    reqAddr = addr;
    #1 q = rdData;
    reqValid = 0; reqOther = 0;
  endtask

  initial begin
    logic [31:0] q;
    logic [5:0] m;
    logic mf;
    logic [5:0] mp;
    int ot;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8 reset values, R7 identity and fixed reads
    chk("R8 pend out", {28'd0, cmpPend}, 0);
    chk("R8 pin out", {8'd0, pinOut}, 0);
    for (int k = 0; k < NC; k++) begin
      rd(k, 0, 4'd0, q); chk("R8 ctl", q, 0);
      rd(k, 0, 4'd1, q); chk("R8 pend", q, 0);
      rd(k, 0, 4'd2, q); chk("R8 mask", q, 32'h32);
      rd(k, 0, 4'd5, q); chk("R8 map", q, 32'h8000_0000);
      rd(k, 0, 4'd8, q); chk("R8 cmplo", q, 32'hFFFF_FFFF);
      rd(k, 0, 4'd6, q); chk("R8 other", q, 0);
      rd(k, 0, 4'd7, q); chk("R7 ident", q, k);
      rd(k, 0, 4'd9, q); chk("R7 cmphi", q, 0);
    end
    // R7 control writes ignored
    wr(1, 0, 4'd0, 32'hFFFF_FFFF);
    rd(1, 0, 4'd0, q); chk("R7 ctl write ignored", q, 0);
    rd(1, 0, 4'd2, q); chk("R7 ctl write no side effect", q, 32'h32);
    // R4 mask sweep
    m = 6'h32;
    for (int d = 0; d < 256; d++) begin
      wr(2, 0, 4'd4, 32'hFFFF_FF00 | d);
      m = m | 6'(d);
      rd(2, 0, 4'd2, q); chk("R4 set mask", q, {26'd0, m});
      wr(2, 0, 4'd3, 32'hAB00_0000 | ((d * 37) & 8'hFF));
      m = m & ~6'((d * 37) & 8'hFF);
      rd(2, 0, 4'd2, q); chk("R4 clear mask", q, {26'd0, m});
    end
    wr(2, 0, 4'd3, 32'h3F);
    wr(2, 0, 4'd4, 32'h32);
    rd(2, 0, 4'd2, q); chk("R4 restore", q, 32'h32);
    // R5 map sweep
    mf = 1; mp = 0;
    for (int p = 0; p < 64; p++) begin
      for (int f = 0; f < 2; f++) begin
        wr(3, 0, 4'd5, (f != 0 ? 32'h8000_0000 : 32'h0) | 32'h0F00_3C00 | p);
        if (p <= MAXP) begin mf = f[0]; mp = 6'(p); end
        rd(3, 0, 4'd5, q); chk("R5 map write", q, {mf, 25'd0, mp});
      end
    end
    // R6 other pointer range and redirect
    ot = 0;
    for (int v = 0; v < 8; v++) begin
      wr(0, 0, 4'd6, v);
      if (v < NC) ot = v;
      rd(0, 0, 4'd6, q); chk("R6 other range", q, ot);
    end
    wr(0, 0, 4'd6, 2);
    wr(0, 1, 4'd8, 32'h0000_1234);
    rd(2, 0, 4'd8, q); chk("R6 redirected write", q, 32'h1234);
    rd(0, 0, 4'd8, q); chk("R6 own bank untouched", q, 32'hFFFF_FFFF);
    rd(0, 1, 4'd7, q); chk("R6 R7 ident via other", q, 2);
    rd(0, 1, 4'd8, q); chk("R6 redirected read", q, 32'h1234);
    // R1 R2 R3 compare match on every core
    for (int k = 0; k < NC; k++) begin
      int p;
      logic [31:0] expPin;
      p = (k + 1) % NP;
      expPin = 32'd1 << (k * NP + p);
      wr(k, 0, 4'd5, 32'h8000_0000 | p);
      wr(k, 0, 4'd8, 100 + k);
      chk("R2 no pend before match", {28'd0, cmpPend}, 0);
      sharedCount = 100 + k;
      @(negedge clk);
      sharedCount = 0;
      chk("R1 match sets pend", {28'd0, cmpPend}, 1 << k);
      chk("R3 mapped pin high", {8'd0, pinOut}, expPin);
      @(negedge clk);
      chk("R1 pend holds", {28'd0, cmpPend}, 1 << k);
      rd(k, 0, 4'd1, q); chk("R1 pend register bit1", q, 2);
      wr(k, 0, 4'd3, 32'h2);
      chk("R3 masked pin low", {8'd0, pinOut}, 0);
      chk("R3 pend kept while masked", {28'd0, cmpPend}, 1 << k);
      wr(k, 0, 4'd4, 32'h2);
      chk("R3 unmasked pin high", {8'd0, pinOut}, expPin);
      wr(k, 0, 4'd5, p);
      chk("R3 flag clear pin low", {8'd0, pinOut}, 0);
      wr(k, 0, 4'd5, 32'h8000_0000 | p);
      chk("R3 flag set pin high", {8'd0, pinOut}, expPin);
      sharedCount = 100 + k;
      wr(k, 0, 4'd8, 500 + k);
      sharedCount = 0;
      chk("R2 write clears over match", {28'd0, cmpPend}, 0);
      chk("R2 pin dropped", {8'd0, pinOut}, 0);
      rd(k, 0, 4'd8, q); chk("R2 compare stored", q, 500 + k);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule